// File: doc/BRIEF.md
# Addressed Serial Configuration Port for a Multi-Channel Motor Driver

This block receives 8-bit configuration frames over a three-wire serial link and turns them into the configuration fields used by two microstep sequencer pairs, two saturated PWM bridges, two constant-current bridges, three sensor drivers, a position monitor and a chopper oscillator. The three wires are a shift clock, a data line and a strobe. All three are oversampled in the system clock domain. A frame is shifted in while the strobe is low. The rising edge of the strobe commits the frame.

The first three bits of a frame form a bank address, and the other five bits fill the fields of the selected bank. Most fields take effect when the strobe rises. Direction and excitation mode of each microstep pair are different: they are staged, and move to the outputs only at the next rising step edge of that pair. A pending flag shows that staged settings are still waiting. For the two constant-current channels, a pair of parallel pins can take over the drive command, and while those pins are active a reference write for that channel is refused.

Top module: `mcp_port_top`

## Requirements
- R1: While the strobe is low, each rising edge of the shift clock shifts in one data bit, first bit as D0 and eighth as D7. Shift-clock edges while the strobe is high leave the shift register unchanged. With more than eight bits, the last eight shifted in form the frame.
- R2: Configuration outputs change only when the strobe rises, except the applied direction and mode (R5) and the parallel override (R6). Address {D2,D1,D0} = 3'b110 selects no bank and changes nothing.
- R3: Address 0 (all three address bits zero) writes pair A, and address 2 (D1 only) writes pair B. In both, mode = {D4,D3} (0 two-phase, 1 half-step full torque, 2 half-step, 3 quarter-step) and level = {D6,D5} (0 full, 1 two-thirds, 2 half, 3 one-third). Level applies at once. In address 2, D7 selects microstep (1) or saturated PWM (0).
- R4: Address 1 (D0 only) writes the pair A control fields and address 3 (D0 and D1) writes the pair B control fields: D3 direction, D4 hold, D5 run (0 holds the position counter in reset), D6 output enable. Hold, run and enable apply when the strobe rises.
- R5: Direction and mode of a pair move to its outputs on the next rising edge of that pair's own step input. A write to either bank of the pair sets its pending flag, and a step edge clears it. A step edge of the other pair has no effect.
- R6: Address 4 (D2 only) sets serial drive commands: channel 5 = {D4,D3}, channel 6 = {D6,D5}, with code 0 off, 1 forward, 2 reverse, 3 brake. If a channel's parallel pin pair {second, first} is not zero, that value drives the channel instead of the serial command (1 forward, 2 reverse, 3 brake).
- R7: Address 5 (D0 and D2) writes a 4-bit reference code {D7,D6,D5,D4} to channel 5 when D3 = 0 and to channel 6 when D3 = 1. The write is dropped if that channel's parallel pins are not both low.
- R8: Address 7 (all three address bits set) has two pages. With D3 = 0 it sets the sensor enables {D6,D5,D4} and the monitor alternate position D7. With D3 = 1 it sets monitor enable D4, monitor pair D5 and chopper select {D7,D6}. Each page leaves the other page's fields unchanged.
- R9: After reset every field is zero, except both output enables, which are one.
- R10: The address 3 frame also sets the saturated commands of pair B: bridge 3 = {D4,D3}, bridge 4 = {D6,D5} (same codes as R6), and fast decay = D7. These take effect when the strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial shift clock (asynchronous) |
| sdata | input | 1 | Serial data (asynchronous) |
| stb | input | 1 | Strobe; low frames a transfer, rising edge commits |
| step_a | input | 1 | Step input of pair A (channels 1/2) |
| step_b | input | 1 | Step input of pair B (channels 3/4) |
| cc5_pin | input | 2 | Channel 5 parallel pins {second, first} |
| cc6_pin | input | 2 | Channel 6 parallel pins {second, first} |
| pa_mode | output | 2 | Pair A applied excitation mode |
| pa_level | output | 2 | Pair A current level |
| pa_dir | output | 1 | Pair A applied direction |
| pa_hold | output | 1 | Pair A step hold |
| pa_run | output | 1 | Pair A counter run (0 = reset) |
| pa_enable | output | 1 | Pair A output enable |
| pa_pending | output | 1 | Pair A staged settings waiting for a step |
| pb_mode | output | 2 | Pair B applied excitation mode |
| pb_level | output | 2 | Pair B current level |
| pb_dir | output | 1 | Pair B applied direction |
| pb_hold | output | 1 | Pair B step hold |
| pb_run | output | 1 | Pair B counter run (0 = reset) |
| pb_enable | output | 1 | Pair B output enable |
| pb_pending | output | 1 | Pair B staged settings waiting for a step |
| pb_micro | output | 1 | Pair B microstep (1) or saturated PWM (0) |
| pb_sat3_cmd | output | 2 | Bridge 3 saturated command |
| pb_sat4_cmd | output | 2 | Bridge 4 saturated command |
| pb_fast_decay | output | 1 | Saturated decay select |
| cc5_drive | output | 2 | Channel 5 effective drive command |
| cc6_drive | output | 2 | Channel 6 effective drive command |
| cc5_ref | output | 4 | Channel 5 reference code |
| cc6_ref | output | 4 | Channel 6 reference code |
| sens_en | output | 3 | Sensor driver enables |
| mon_en | output | 1 | Monitor output selected |
| mon_pair | output | 1 | Monitor source pair (0 A, 1 B) |
| mon_alt_pos | output | 1 | Monitor alternate position select |
| chop_sel | output | 2 | Chopper frequency select |

## Verification
The bench uses the default two-stage synchronizer, and the serial and step signals are held for several system clocks. This covers the full path: pin, synchronizer, edge detector, register. It covers partial frames mixed with shift-clock pulses during a high strobe, so that a dropped or accepted stray bit moves the address bits of the frame and shows up at the outputs. The parallel pins are toggled between reference writes to both channels to cover the gating and the override, including a write to one channel while only the other channel's pins are active.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
    localparam int FRAME_W = 8;
    localparam int ADDR_W  = 3;
    localparam int FLD_W   = FRAME_W - ADDR_W;
    localparam int MODE_W  = 2;
    localparam int LVL_W   = 2;
    localparam int CMD_W   = 2;
    localparam int REF_W   = 4;
    localparam int SENS_N  = 3;
    localparam int CHOP_W  = 2;

    // Bank addresses as {D2,D1,D0}
    localparam logic [ADDR_W-1:0] BANK_MODE_A = 3'd0;
    localparam logic [ADDR_W-1:0] BANK_CTL_A  = 3'd1;
    localparam logic [ADDR_W-1:0] BANK_MODE_B = 3'd2;
    localparam logic [ADDR_W-1:0] BANK_CTL_B  = 3'd3;
    localparam logic [ADDR_W-1:0] BANK_DRIVE  = 3'd4;
    localparam logic [ADDR_W-1:0] BANK_REF    = 3'd5;
    localparam logic [ADDR_W-1:0] BANK_SYS    = 3'd7;
endpackage

// File: rtl/mcp_sync.sv
// Multi-bit level synchronizer: each bit passes through STAGES flops.
// Assumes the inputs are independent levels; no bus coherency is implied.
// INIT gives the reset value per bit so an idle-high line does not
// produce a false edge after reset.
module mcp_sync #(
    parameter int             W      = 4,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   INIT   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        // shift the raw input through the synchronizer chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{INIT[g]}};
            else        chain <= {chain[STAGES-2:0], din[g]};
        end
        assign dout[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/mcp_shifter.sv
// Serial-in frame register. Shifts toward bit 0 so that after eight
// accepted clocks bit k holds the k-th transmitted bit.
// Assumes sclk_rise and sdata are already synchronized and aligned.
module mcp_shifter
    import mcp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_rise,
    input  logic               stb_level,
    input  logic               sdata,
    output logic [FRAME_W-1:0] frame
);
    logic accept;
    assign accept = sclk_rise && !stb_level;

    // shift one bit in per accepted shift-clock edge
    always_ff @(posedge clk) begin
        if (!rst_n)      frame <= '0;
        else if (accept) frame <= {sdata, frame[FRAME_W-1:1]};
    end

    assert_ignore_when_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && stb_level) |=> $stable(frame));
endmodule

// File: rtl/mcp_pair_regs.sv
// Register set for one microstep pair. Level, hold, run and enable are
// written directly; direction and mode are staged and copied to the
// applied outputs on the pair's step edge. pending marks staged data.
// Assumes wr_mode / wr_ctl are single-cycle pulses from the decoder.
module mcp_pair_regs
    import mcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mode,
    input  logic              wr_ctl,
    input  logic [3:0]        fld,      // D6..D3
    input  logic              step_rise,
    output logic [MODE_W-1:0] mode,
    output logic [LVL_W-1:0]  level,
    output logic              dir,
    output logic              hold,
    output logic              run,
    output logic              enable,
    output logic              pending
);
    logic [MODE_W-1:0] mode_stg;
    logic              dir_stg;

    // staging, application on step edge and immediate fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_stg <= '0;
            dir_stg  <= 1'b0;
            mode     <= '0;
            dir      <= 1'b0;
            level    <= '0;
            hold     <= 1'b0;
            run      <= 1'b0;
            enable   <= 1'b1;
            pending  <= 1'b0;
        end else begin
            if (step_rise) begin
                mode    <= mode_stg;
                dir     <= dir_stg;
                pending <= 1'b0;
            end
            if (wr_mode) begin
                mode_stg <= fld[1:0];
                level    <= fld[3:2];
                pending  <= 1'b1;
            end
            if (wr_ctl) begin
                dir_stg <= fld[0];
                hold    <= fld[1];
                run     <= fld[2];
                enable  <= fld[3];
                pending <= 1'b1;
            end
        end
    end

    assert_apply_on_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !step_rise |=> ($stable(dir) && $stable(mode)));
    assert_pending_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_rise && !wr_mode && !wr_ctl) |=> !pending);
    assert_ctl_immediate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> (enable == $past(fld[3]) && run == $past(fld[2])));
endmodule

// File: rtl/mcp_aux_regs.sv
// Registers for the constant-current channels, sensor drivers, monitor
// and chopper. Applies the parallel-pin override and the reference
// write gate. Assumes the parallel pins arrive synchronized.
module mcp_aux_regs
    import mcp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_drive,
    input  logic               wr_ref,
    input  logic               wr_sys,
    input  logic [FLD_W-1:0]   fld,      // D7..D3
    input  logic [1:0]         pin5,
    input  logic [1:0]         pin6,
    output logic [CMD_W-1:0]   drive5,
    output logic [CMD_W-1:0]   drive6,
    output logic [REF_W-1:0]   ref5,
    output logic [REF_W-1:0]   ref6,
    output logic [SENS_N-1:0]  sens_en,
    output logic               mon_en,
    output logic               mon_pair,
    output logic               mon_alt_pos,
    output logic [CHOP_W-1:0]  chop_sel
);
    logic [CMD_W-1:0] ser5, ser6;
    logic             pins5_idle, pins6_idle;

    assign pins5_idle = (pin5 == 2'b00);
    assign pins6_idle = (pin6 == 2'b00);

    // serial drive commands and gated reference codes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser5 <= '0;
            ser6 <= '0;
            ref5 <= '0;
            ref6 <= '0;
        end else begin
            if (wr_drive) begin
                ser5 <= fld[1:0];
                ser6 <= fld[3:2];
            end
            if (wr_ref && !fld[0] && pins5_idle) ref5 <= fld[4:1];
            if (wr_ref &&  fld[0] && pins6_idle) ref6 <= fld[4:1];
        end
    end

    // two-page system bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sens_en     <= '0;
            mon_alt_pos <= 1'b0;
            mon_en      <= 1'b0;
            mon_pair    <= 1'b0;
            chop_sel    <= '0;
        end else if (wr_sys) begin
            if (!fld[0]) begin
                sens_en     <= fld[3:1];
                mon_alt_pos <= fld[4];
            end else begin
                mon_en   <= fld[1];
                mon_pair <= fld[2];
                chop_sel <= fld[4:3];
            end
        end
    end

    // parallel pins take over whenever either one is high
    assign drive5 = pins5_idle ? ser5 : pin5;
    assign drive6 = pins6_idle ? ser6 : pin6;

    assert_ref5_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ref && !fld[0] && !pins5_idle) |=> $stable(ref5));
    assert_ref6_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ref && fld[0] && !pins6_idle) |=> $stable(ref6));
endmodule

// File: rtl/mcp_port_top.sv
// Addressed serial configuration port. Synchronizes the three serial
// wires, the step lines and the parallel pins, assembles frames, decodes
// the bank address on the strobe edge and routes fields to the banks.
// Assumes every serial/step level lasts several system clocks.
module mcp_port_top
    import mcp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdata,
    input  logic              stb,
    input  logic              step_a,
    input  logic              step_b,
    input  logic [1:0]        cc5_pin,
    input  logic [1:0]        cc6_pin,
    output logic [MODE_W-1:0] pa_mode,
    output logic [LVL_W-1:0]  pa_level,
    output logic              pa_dir,
    output logic              pa_hold,
    output logic              pa_run,
    output logic              pa_enable,
    output logic              pa_pending,
    output logic [MODE_W-1:0] pb_mode,
    output logic [LVL_W-1:0]  pb_level,
    output logic              pb_dir,
    output logic              pb_hold,
    output logic              pb_run,
    output logic              pb_enable,
    output logic              pb_pending,
    output logic              pb_micro,
    output logic [CMD_W-1:0]  pb_sat3_cmd,
    output logic [CMD_W-1:0]  pb_sat4_cmd,
    output logic              pb_fast_decay,
    output logic [CMD_W-1:0]  cc5_drive,
    output logic [CMD_W-1:0]  cc6_drive,
    output logic [REF_W-1:0]  cc5_ref,
    output logic [REF_W-1:0]  cc6_ref,
    output logic [SENS_N-1:0] sens_en,
    output logic              mon_en,
    output logic              mon_pair,
    output logic              mon_alt_pos,
    output logic [CHOP_W-1:0] chop_sel
);
    localparam int NSYNC = 9;
    localparam int NEDGE = 4;
    // bit order: {cc6[1:0], cc5[1:0], step_b, step_a, stb, sdata, sclk}
    localparam logic [NSYNC-1:0] SYNC_INIT = 9'b0_0000_0100;
    localparam logic [NEDGE-1:0] EDGE_INIT = 4'b0010;

    logic [NSYNC-1:0]   raw, lvl;
    logic [NEDGE-1:0]   edge_now, edge_q, rise;
    logic [FRAME_W-1:0] frame;
    logic [ADDR_W-1:0]  addr;
    logic [FLD_W-1:0]   fld;
    logic               commit;
    logic [FLD_W-1:0]   sat_q;

    assign raw = {cc6_pin, cc5_pin, step_b, step_a, stb, sdata, sclk};

    mcp_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .INIT(SYNC_INIT)) sync_i (
        .clk(clk), .rst_n(rst_n), .din(raw), .dout(lvl));

    // {step_b, step_a, stb, sclk}
    assign edge_now = {lvl[4], lvl[3], lvl[2], lvl[0]};

    // previous level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) edge_q <= EDGE_INIT;
        else        edge_q <= edge_now;
    end
    assign rise = edge_now & ~edge_q;

    mcp_shifter shift_i (
        .clk(clk), .rst_n(rst_n), .sclk_rise(rise[0]), .stb_level(lvl[2]),
        .sdata(lvl[1]), .frame(frame));

    assign commit = rise[1];
    assign addr   = frame[ADDR_W-1:0];
    assign fld    = frame[FRAME_W-1:ADDR_W];

    mcp_pair_regs pair_a_i (
        .clk(clk), .rst_n(rst_n),
        .wr_mode(commit && addr == BANK_MODE_A),
        .wr_ctl(commit && addr == BANK_CTL_A),
        .fld(fld[3:0]), .step_rise(rise[2]),
        .mode(pa_mode), .level(pa_level), .dir(pa_dir), .hold(pa_hold),
        .run(pa_run), .enable(pa_enable), .pending(pa_pending));

    mcp_pair_regs pair_b_i (
        .clk(clk), .rst_n(rst_n),
        .wr_mode(commit && addr == BANK_MODE_B),
        .wr_ctl(commit && addr == BANK_CTL_B),
        .fld(fld[3:0]), .step_rise(rise[3]),
        .mode(pb_mode), .level(pb_level), .dir(pb_dir), .hold(pb_hold),
        .run(pb_run), .enable(pb_enable), .pending(pb_pending));

    // pair B drive style and saturated-mode fields, both immediate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pb_micro <= 1'b0;
            sat_q    <= '0;
        end else if (commit) begin
            if (addr == BANK_MODE_B) pb_micro <= fld[4];
            if (addr == BANK_CTL_B)  sat_q    <= fld;
        end
    end
    assign pb_sat3_cmd   = sat_q[1:0];
    assign pb_sat4_cmd   = sat_q[3:2];
    assign pb_fast_decay = sat_q[4];

    mcp_aux_regs aux_i (
        .clk(clk), .rst_n(rst_n),
        .wr_drive(commit && addr == BANK_DRIVE),
        .wr_ref(commit && addr == BANK_REF),
        .wr_sys(commit && addr == BANK_SYS),
        .fld(fld), .pin5(lvl[6:5]), .pin6(lvl[8:7]),
        .drive5(cc5_drive), .drive6(cc6_drive), .ref5(cc5_ref), .ref6(cc6_ref),
        .sens_en(sens_en), .mon_en(mon_en), .mon_pair(mon_pair),
        .mon_alt_pos(mon_alt_pos), .chop_sel(chop_sel));

    assert_quiet_without_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(pb_micro) && $stable(sat_q) && $stable(pa_level)
                     && $stable(cc5_ref) && $stable(sens_en)));
endmodule

// File: tb/mcp_port_top_tb_top.sv
module mcp_port_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdata = 1'b0, stb = 1'b1, step_a = 1'b0, step_b = 1'b0;
    logic [1:0] cc5_pin = 2'b00, cc6_pin = 2'b00;
    logic [1:0] pa_mode, pa_level, pb_mode, pb_level;
    logic pa_dir, pa_hold, pa_run, pa_enable, pa_pending;
    logic pb_dir, pb_hold, pb_run, pb_enable, pb_pending, pb_micro, pb_fast_decay;
    logic [1:0] pb_sat3_cmd, pb_sat4_cmd, cc5_drive, cc6_drive, chop_sel;
    logic [3:0] cc5_ref, cc6_ref;
    logic [2:0] sens_en;
    logic mon_en, mon_pair, mon_alt_pos;
    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mcp_port_top dut_i (.*);

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // frame with address {D2,D1,D0} and payload p[0]=D3 .. p[4]=D7
    function automatic logic [7:0] mk(input logic [2:0] a, input logic [4:0] p);
        return {p, a};
    endfunction

    task automatic shift_bits(input int n, input logic [7:0] d);
        stb = 1'b0; tick(4);
        for (int i = 0; i < n; i++) begin
            sdata = d[i]; tick(4);
            sclk = 1'b1; tick(4);
            sclk = 1'b0; tick(2);
        end
    endtask

    task automatic raise_stb();
        stb = 1'b1; tick(12);
    endtask

    task automatic send(input logic [7:0] d);
        shift_bits(8, d); raise_stb();
    endtask

    task automatic stray_clocks(input int n, input logic v);
        for (int i = 0; i < n; i++) begin
            sdata = v; tick(4); sclk = 1'b1; tick(4); sclk = 1'b0; tick(4);
        end
    endtask

    task automatic pulse_a(); step_a = 1'b1; tick(8); step_a = 1'b0; tick(8); endtask
    task automatic pulse_b(); step_b = 1'b1; tick(8); step_b = 1'b0; tick(8); endtask

    task automatic t_reset();
        check("R9 pa_enable", pa_enable, 1);
        check("R9 pb_enable", pb_enable, 1);
        check("R9 pa_run", pa_run, 0);
        check("R9 pa_level", pa_level, 0);
        check("R9 cc5_ref", cc5_ref, 0);
        check("R9 cc6_drive", cc6_drive, 0);
        check("R9 pending", {pa_pending, pb_pending}, 0);
        check("R9 chop_sel", chop_sel, 0);
    endtask

    task automatic t_mode_a();
        send(mk(3'd0, 5'b01011));
        check("R3 pa_level immediate", pa_level, 2);
        check("R5 pa_mode deferred", pa_mode, 0);
        check("R5 pa_pending set", pa_pending, 1);
        pulse_a();
        check("R5 pa_mode applied", pa_mode, 3);
        check("R5 pa_pending cleared", pa_pending, 0);
    endtask

    task automatic t_ctl_a();
        send(mk(3'd1, 5'b00111));
        check("R4 pa_hold", pa_hold, 1);
        check("R4 pa_run", pa_run, 1);
        check("R4 pa_enable", pa_enable, 0);
        check("R5 pa_dir deferred", pa_dir, 0);
        pulse_b();
        check("R5 other pair step ignored", pa_dir, 0);
        pulse_a();
        check("R5 pa_dir applied", pa_dir, 1);
    endtask

    task automatic t_stray();
        send(mk(3'd0, 5'b01011));
        stray_clocks(3, 1'b1);
        shift_bits(3, 8'b0000_0101);
        raise_stb();
        // frame now {1,0,1,0,1,0,1,1}: address 3, D3=1 D4=0 D5=1 D6=0 D7=1
        check("R1 pb_enable from stray-free frame", pb_enable, 0);
        check("R1 pb_run", pb_run, 1);
        check("R10 pb_fast_decay", pb_fast_decay, 1);
        check("R1 cc6_ref untouched", cc6_ref, 0);
        check("R5 pb_dir deferred", pb_dir, 0);
        pulse_b();
        check("R5 pb_dir applied", pb_dir, 1);
    endtask

    task automatic t_mode_b();
        send(mk(3'd2, 5'b01110));
        check("R3 pb_level", pb_level, 3);
        check("R3 pb_micro", pb_micro, 0);
        pulse_b();
        check("R3 pb_mode", pb_mode, 2);
        send(mk(3'd3, 5'b01101));
        check("R10 pb_sat3_cmd", pb_sat3_cmd, 1);
        check("R10 pb_sat4_cmd", pb_sat4_cmd, 3);
        check("R10 pb_fast_decay", pb_fast_decay, 0);
        check("R4 pb_hold", pb_hold, 0);
        check("R4 pb_enable", pb_enable, 1);
    endtask

    task automatic t_drive();
        send(mk(3'd4, 5'b00110));
        check("R6 cc5_drive serial", cc5_drive, 2);
        check("R6 cc6_drive serial", cc6_drive, 1);
        cc5_pin = 2'b11; tick(8);
        check("R6 cc5 override brake", cc5_drive, 3);
        check("R6 cc6 unaffected", cc6_drive, 1);
        cc5_pin = 2'b01; tick(8);
        check("R6 cc5 override forward", cc5_drive, 1);
        cc5_pin = 2'b00; tick(8);
        check("R6 cc5 back to serial", cc5_drive, 2);
    endtask

    task automatic t_ref();
        send(mk(3'd5, 5'b10100));
        check("R7 cc5_ref write", cc5_ref, 10);
        check("R7 cc6_ref untouched", cc6_ref, 0);
        send(mk(3'd5, 5'b00111));
        check("R7 cc6_ref write", cc6_ref, 3);
        cc6_pin = 2'b10; tick(8);
        check("R6 cc6 override reverse", cc6_drive, 2);
        send(mk(3'd5, 5'b11111));
        check("R7 cc6_ref gated", cc6_ref, 3);
        cc6_pin = 2'b00; cc5_pin = 2'b01; tick(8);
        send(mk(3'd5, 5'b01111));
        check("R7 cc6_ref open while cc5 pins active", cc6_ref, 7);
        send(mk(3'd5, 5'b11110));
        check("R7 cc5_ref gated", cc5_ref, 10);
        cc5_pin = 2'b00; tick(8);
    endtask

    task automatic t_sys();
        send(mk(3'd7, 5'b11010));
        check("R8 sens_en", sens_en, 5);
        check("R8 mon_alt_pos", mon_alt_pos, 1);
        check("R8 mon_en other page", mon_en, 0);
        send(mk(3'd7, 5'b10111));
        check("R8 mon_en", mon_en, 1);
        check("R8 mon_pair", mon_pair, 1);
        check("R8 chop_sel", chop_sel, 2);
        check("R8 sens_en kept", sens_en, 5);
    endtask

    task automatic t_unmapped_and_commit();
        send(mk(3'd6, 5'b11111));
        check("R2 unmapped pa_level", pa_level, 2);
        check("R2 unmapped cc5_ref", cc5_ref, 10);
        check("R2 unmapped sens_en", sens_en, 5);
        check("R2 unmapped pb_enable", pb_enable, 1);
        check("R2 unmapped cc5_drive", cc5_drive, 2);
        shift_bits(8, mk(3'd0, 5'b00100));
        tick(8);
        check("R2 no change before strobe", pa_level, 2);
        raise_stb();
        check("R2 change after strobe", pa_level, 1);
    endtask

    initial begin
        tick(6);
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_mode_a();
        t_ctl_a();
        t_stray();
        t_mode_b();
        t_drive();
        t_ref();
        t_sys();
        t_unmapped_and_commit();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule